// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block sits beside an integer datapath and owns a pair of result registers, HI and LO, that together form one double-width accumulator. A caller presents a 6-bit function code with two operands and pulses a start strobe. The block then runs one of these operations: a signed or unsigned multiply, a multiply that adds to or subtracts from the accumulator, a signed or unsigned divide, or a move into or out of HI or LO. Multiplication can be built as a single-cycle stage or as a two-cycle registered stage, chosen by a parameter. Division runs a restoring algorithm that produces one quotient bit per cycle.

Divide-by-zero and the one signed quotient that overflows do not iterate. Each gives a fixed result in the same cycle. While a divide runs, the unit reports busy and refuses new work. A read of HI or LO asked for during that time is refused until the unit is idle, so the caller holds its request and waits.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: With the default single-cycle multiplier, function 24 (signed) and function 25 (unsigned) write the 64-bit product of rs and rt to HI:LO, with the low half in LO. HI, LO and done all change on the clock edge that accepts the start.
- R2: Functions 28 (signed) and 29 (unsigned) add the product to the 64-bit HI:LO value. Functions 46 (signed) and 47 (unsigned) subtract the product from it. A carry or borrow passes between LO and HI.
- R3: Function 17 copies rs into HI and function 19 copies rs into LO. The other register is left unchanged.
- R4: Function 16 selects HI and function 18 selects LO for rd_data. rd_valid is high in the same cycle when start is high and the unit is idle. rd_valid stays low while busy is high.
- R5: Functions 26 (signed) and 27 (unsigned) put the quotient in LO and the remainder in HI. A signed quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R6: A divide that is not a special case holds busy high for exactly 32 cycles. busy falls and done pulses on the same clock edge that writes HI and LO.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0xFFFFFFFF.
- R8: A signed divide by zero sets HI to the dividend. LO becomes 1 when the dividend is negative and 0xFFFFFFFF otherwise.
- R9: An unsigned divide by zero sets HI to the dividend. LO becomes 0x0000FFFF when the dividend is at most 0xFFFF and 0xFFFFFFFF otherwise.
- R10: The special divide cases of R7 to R9 finish on the accepting edge. busy is never raised for them, and done is high in the following cycle.
- R11: A start that arrives while busy is high has no effect. A function code outside the twelve listed ones also has no effect. In both cases HI and LO keep their values and done stays low.
- R12: After reset, HI and LO are zero and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when busy is low |
| func | input | 6 | Function code of the request |
| rs_val | input | 32 | First operand (dividend, multiplicand, or move source) |
| rt_val | input | 32 | Second operand (divisor or multiplier) |
| busy | output | 1 | Operation in progress; new requests are refused |
| done | output | 1 | One-cycle pulse after HI or LO has been written |
| hi_q | output | 32 | Current contents of HI |
| lo_q | output | 32 | Current contents of LO |
| rd_valid | output | 1 | A read of HI or LO is granted this cycle |
| rd_data | output | 32 | Read data for a read of HI or LO |

## Verification
The bench checks the signed-overflow quotient and both divide-by-zero forms, including both sides of the 0xFFFF threshold. A design that let these cases reach the iterator would return an arbitrary quotient and would also raise busy. It divides operands with mixed signs, where a unit that takes the magnitude without restoring the signs would return a wrong sign or a rounded-down quotient. It also accumulates across the LO/HI boundary, where a missing carry or borrow corrupts HI. During a divide it issues a read and a move, then checks that the read is refused and that the move leaves no trace in HI. It counts the busy cycles, so an iterator that is off by one step is caught.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [5:0] {
      FN_MFHI  = 6'd16,
      FN_MTHI  = 6'd17,
      FN_MFLO  = 6'd18,
      FN_MTLO  = 6'd19,
      FN_MULT  = 6'd24,
      FN_MULTU = 6'd25,
      FN_DIV   = 6'd26,
      FN_DIVU  = 6'd27,
      FN_MADD  = 6'd28,
      FN_MADDU = 6'd29,
      FN_MSUB  = 6'd46,
      FN_MSUBU = 6'd47
   } mdu_fn_e;

   typedef enum logic [1:0] {
      ACC_SET = 2'd0,
      ACC_ADD = 2'd1,
      ACC_SUB = 2'd2
   } acc_mode_e;

   typedef struct packed {
      logic      is_mul;
      logic      is_div;
      logic      sgn;
      acc_mode_e acc;
      logic      wr_hi;
      logic      wr_lo;
      logic      rd_hi;
      logic      rd_lo;
   } mdu_dec_t;

   function automatic mdu_dec_t mdu_decode(input logic [5:0] f);
      mdu_dec_t d;
      d = '{is_mul: 1'b0, is_div: 1'b0, sgn: 1'b0, acc: ACC_SET,
            wr_hi: 1'b0, wr_lo: 1'b0, rd_hi: 1'b0, rd_lo: 1'b0};
      case (f)
         FN_MFHI:  d.rd_hi = 1'b1;
         FN_MFLO:  d.rd_lo = 1'b1;
         FN_MTHI:  d.wr_hi = 1'b1;
         FN_MTLO:  d.wr_lo = 1'b1;
         FN_MULT:  begin d.is_mul = 1'b1; d.sgn = 1'b1; end
         FN_MULTU: d.is_mul = 1'b1;
         FN_MADD:  begin d.is_mul = 1'b1; d.sgn = 1'b1; d.acc = ACC_ADD; end
         FN_MADDU: begin d.is_mul = 1'b1; d.acc = ACC_ADD; end
         FN_MSUB:  begin d.is_mul = 1'b1; d.sgn = 1'b1; d.acc = ACC_SUB; end
         FN_MSUBU: begin d.is_mul = 1'b1; d.acc = ACC_SUB; end
         FN_DIV:   begin d.is_div = 1'b1; d.sgn = 1'b1; end
         FN_DIVU:  d.is_div = 1'b1;
         default:  d = d;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/mdu_mul_stage.sv
module mdu_mul_stage #(
   parameter int XLEN    = 32,
   parameter int LATENCY = 0,
   localparam int PW     = 2 * XLEN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            sgn,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [PW-1:0]   prod,
   output logic            valid,
   output logic            pending
);

   if (LATENCY != 0 && LATENCY != 1) begin : g_bad_latency
      $error("mdu_mul_stage: LATENCY must be 0 or 1");
   end

   logic signed [XLEN:0]   ext_a;
   logic signed [XLEN:0]   ext_b;
   logic signed [PW-1:0]   full;

   always_comb begin
      ext_a = {sgn & a[XLEN-1], a};
      ext_b = {sgn & b[XLEN-1], b};
      full  = ext_a * ext_b;
   end

   if (LATENCY == 0) begin : g_comb
      assign prod    = full;
      assign valid   = go;
      assign pending = 1'b0;
   end else begin : g_reg
      logic [PW-1:0] prod_q;
      logic          valid_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q  <= '0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= go;
            if (go) prod_q <= full;
         end
      end
      assign prod    = prod_q;
      assign valid   = valid_q;
      assign pending = valid_q;

      a_r1_reg_valid_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
         go |=> valid);
   end

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
   parameter int XLEN  = 32,
   localparam int ITERS = XLEN,
   localparam int CW    = $clog2(ITERS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            sgn,
   input  logic [XLEN-1:0] dividend,
   input  logic [XLEN-1:0] divisor,
   output logic            busy,
   output logic            res_valid,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);

   localparam logic [XLEN-1:0] MIN_NEG  = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};
   localparam logic [XLEN-1:0] HALF_MSK = {{(XLEN/2){1'b0}}, {(XLEN/2){1'b1}}};
   localparam logic [CW-1:0]   CNT_INIT = CW'(ITERS);
   localparam logic [CW-1:0]   CNT_LAST = CW'(1);

   logic            a_neg, b_neg, div_zero, ovf, special;
   logic [XLEN-1:0] a_mag, b_mag, sp_quo, sp_rem;

   always_comb begin
      a_neg    = sgn & dividend[XLEN-1];
      b_neg    = sgn & divisor[XLEN-1];
      a_mag    = a_neg ? -dividend : dividend;
      b_mag    = b_neg ? -divisor : divisor;
      div_zero = (divisor == '0);
      ovf      = sgn && (dividend == MIN_NEG) && (divisor == ALL_ONES);
      special  = div_zero | ovf;
      if (div_zero) begin
         sp_rem = dividend;
         if (sgn) sp_quo = dividend[XLEN-1] ? XLEN'(1) : ALL_ONES;
         else     sp_quo = (dividend <= HALF_MSK) ? HALF_MSK : ALL_ONES;
      end else begin
         sp_rem = ALL_ONES;
         sp_quo = MIN_NEG;
      end
   end

   logic            busy_q, negq_q, negr_q;
   logic [CW-1:0]   cnt_q;
   logic [XLEN-1:0] rem_q, quo_q, dvs_q;

   logic [XLEN:0]   shifted, trial;
   logic            take, last;
   logic [XLEN-1:0] nrem, nquo, fin_q, fin_r;

   always_comb begin
      shifted = {rem_q, quo_q[XLEN-1]};
      trial   = shifted - {1'b0, dvs_q};
      take    = ~trial[XLEN];
      nrem    = take ? trial[XLEN-1:0] : shifted[XLEN-1:0];
      nquo    = {quo_q[XLEN-2:0], take};
      fin_q   = negq_q ? -nquo : nquo;
      fin_r   = negr_q ? -nrem : nrem;
      last    = busy_q && (cnt_q == CNT_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
         cnt_q  <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         dvs_q  <= '0;
      end else if (go && !special) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_INIT;
         rem_q  <= '0;
         quo_q  <= a_mag;
         dvs_q  <= b_mag;
         negq_q <= a_neg ^ b_neg;
         negr_q <= a_neg;
      end else if (busy_q) begin
         rem_q <= nrem;
         quo_q <= nquo;
         cnt_q <= cnt_q - CW'(1);
         if (last) busy_q <= 1'b0;
      end
   end

   assign busy      = busy_q;
   assign res_valid = (go && special) || last;
   assign quo       = last ? fin_q : sp_quo;
   assign rem       = last ? fin_r : sp_rem;

   // R10: a special case never starts the iterator
   a_r10_special_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (go && special) |=> !busy_q);

   // R6: the iterator is always counting while it is busy
   a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q != '0));

   // R8 / R9: divide by zero returns the dividend as remainder
   always_comb begin
      if (rst_n && go && div_zero) begin
         a_r8_zero_keeps_dividend: assert (rem == dividend);
      end
   end

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
   import mdu_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int MUL_LATENCY = 0,
   localparam int PW         = 2 * XLEN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [5:0]      func,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] hi_q,
   output logic [XLEN-1:0] lo_q,
   output logic            rd_valid,
   output logic [XLEN-1:0] rd_data
);

   if (XLEN < 8 || (XLEN % 2) != 0) begin : g_bad_width
      $error("hilo_muldiv_unit: XLEN must be even and at least 8");
   end

   mdu_dec_t        dec;
   logic            accept, mul_go, div_go;
   logic [PW-1:0]   prod, hilo_cur, acc_next;
   logic            mul_valid, mul_pend;
   logic            div_busy, div_valid;
   logic [XLEN-1:0] div_quo, div_rem;
   acc_mode_e       acc_q, acc_use;
   logic            done_q;

   always_comb begin
      dec    = mdu_decode(func);
      accept = start && !busy;
      mul_go = accept && dec.is_mul;
      div_go = accept && dec.is_div;
   end

   mdu_mul_stage #(.XLEN(XLEN), .LATENCY(MUL_LATENCY)) mul_i (
      .clk(clk), .rst_n(rst_n), .go(mul_go), .sgn(dec.sgn),
      .a(rs_val), .b(rt_val), .prod(prod), .valid(mul_valid), .pending(mul_pend)
   );

   mdu_div_core #(.XLEN(XLEN)) div_i (
      .clk(clk), .rst_n(rst_n), .go(div_go), .sgn(dec.sgn),
      .dividend(rs_val), .divisor(rt_val), .busy(div_busy),
      .res_valid(div_valid), .quo(div_quo), .rem(div_rem)
   );

   assign busy = div_busy | mul_pend;

   always_comb begin
      acc_use  = (MUL_LATENCY == 0) ? dec.acc : acc_q;
      hilo_cur = {hi_q, lo_q};
      case (acc_use)
         ACC_ADD: acc_next = hilo_cur + prod;
         ACC_SUB: acc_next = hilo_cur - prod;
         default: acc_next = prod;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         acc_q  <= ACC_SET;
         done_q <= 1'b0;
      end else begin
         if (mul_go) acc_q <= dec.acc;
         done_q <= mul_valid | div_valid | (accept & (dec.wr_hi | dec.wr_lo));
         if (mul_valid) begin
            {hi_q, lo_q} <= acc_next;
         end else if (div_valid) begin
            hi_q <= div_rem;
            lo_q <= div_quo;
         end else if (accept) begin
            if (dec.wr_hi) hi_q <= rs_val;
            if (dec.wr_lo) lo_q <= rs_val;
         end
      end
   end

   assign done     = done_q;
   assign rd_valid = start && !busy && (dec.rd_hi | dec.rd_lo);
   assign rd_data  = dec.rd_hi ? hi_q : lo_q;

   // R6: completion of an iterated divide is flagged on the edge busy drops
   a_r6_done_at_div_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(div_busy) |-> done);

   // R4: no read is granted while the divider is running
   a_r4_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !rd_valid);

   // R11: HI and LO hold while a divide iterates
   a_r11_hold_during_div: assert property (@(posedge clk) disable iff (!rst_n)
      (div_busy && !div_valid) |=> ($stable(hi_q) && $stable(lo_q)));

   // R1: a multiply result is always followed by done
   a_r1_mul_done: assert property (@(posedge clk) disable iff (!rst_n)
      mul_valid |=> done);

   // R3: a move to HI leaves LO alone
   a_r3_mthi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec.wr_hi) |=> $stable(lo_q));

endmodule

// File: tb/hilo_muldiv_unit_tb_top.sv
module hilo_muldiv_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  func = 6'd0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic        busy, done, rd_valid;
   logic [31:0] hi_q, lo_q, rd_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_hi = '0;
   logic [31:0] m_lo = '0;

   always #10 clk = ~clk;

   hilo_muldiv_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .func(func),
      .rs_val(rs_val), .rt_val(rt_val), .busy(busy), .done(done),
      .hi_q(hi_q), .lo_q(lo_q), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      func = f; rs_val = a; rt_val = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   function automatic logic [63:0] mul64(input logic [31:0] a, input logic [31:0] b, input bit s);
      longint sa, sb;
      if (s) begin
         sa = longint'($signed(a));
         sb = longint'($signed(b));
         return 64'(sa * sb);
      end
      return {32'd0, a} * {32'd0, b};
   endfunction

   task automatic t_reset();
      chk("R12 hi", {32'd0, hi_q}, 64'd0);
      chk("R12 lo", {32'd0, lo_q}, 64'd0);
      chk("R12 busy/done", {62'd0, busy, done}, 64'd0);
   endtask

   task automatic t_mult(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input bit s);
      logic [63:0] p;
      p = mul64(a, b, s);
      issue(f, a, b);
      chk("R1 done next cycle", {63'd0, done}, 64'd1);
      chk("R1 product", {hi_q, lo_q}, p);
      {m_hi, m_lo} = p;
   endtask

   task automatic t_accum(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                          input bit s, input bit sub);
      logic [63:0] e;
      e = sub ? ({m_hi, m_lo} - mul64(a, b, s)) : ({m_hi, m_lo} + mul64(a, b, s));
      issue(f, a, b);
      chk("R2 accumulate", {hi_q, lo_q}, e);
      {m_hi, m_lo} = e;
   endtask

   task automatic t_moves(input logic [31:0] h, input logic [31:0] l);
      issue(6'd17, h, 32'd0);
      m_hi = h;
      chk("R3 mthi", {hi_q, lo_q}, {m_hi, m_lo});
      issue(6'd19, l, 32'd0);
      m_lo = l;
      chk("R3 mtlo", {hi_q, lo_q}, {m_hi, m_lo});
      @(negedge clk);
      func = 6'd16; start = 1'b1; #1;
      chk("R4 mfhi", {31'd0, rd_valid, rd_data}, {31'd0, 1'b1, m_hi});
      func = 6'd18; #1;
      chk("R4 mflo", {31'd0, rd_valid, rd_data}, {31'd0, 1'b1, m_lo});
      start = 1'b0;
   endtask

   task automatic t_div(input logic [31:0] a, input logic [31:0] b, input bit s, input bit probe);
      logic [31:0] eq, er;
      int cnt;
      if (s) begin
         eq = 32'($signed(a) / $signed(b));
         er = 32'($signed(a) % $signed(b));
      end else begin
         eq = a / b;
         er = a % b;
      end
      issue(s ? 6'd26 : 6'd27, a, b);
      cnt = 0;
      while (busy && cnt < 100) begin
         if (probe && cnt == 3) begin
            func = 6'd18; start = 1'b1; #1;
            chk("R4 read stalled while busy", {63'd0, rd_valid}, 64'd0);
         end
         if (probe && cnt == 4) begin
            func = 6'd17; rs_val = 32'hDEAD_BEEF; start = 1'b1;
         end
         if (cnt == 5) start = 1'b0;
         cnt++;
         @(negedge clk);
      end
      chk("R6 busy cycles", 64'(cnt), 64'd32);
      chk("R6 done at end", {63'd0, done}, 64'd1);
      chk(probe ? "R11 R5 result after ignored start" : "R5 quotient/remainder",
          {hi_q, lo_q}, {er, eq});
      m_hi = er; m_lo = eq;
   endtask

   task automatic t_special(input string req, input logic [31:0] a, input logic [31:0] b,
                            input bit s, input logic [31:0] eh, input logic [31:0] el);
      issue(s ? 6'd26 : 6'd27, a, b);
      chk("R10 no busy, done", {62'd0, busy, done}, 64'd1);
      chk(req, {hi_q, lo_q}, {eh, el});
      m_hi = eh; m_lo = el;
   endtask

   task automatic t_illegal(input logic [5:0] f);
      issue(f, 32'h1234_5678, 32'h9ABC_DEF0);
      chk("R11 unknown code no done", {63'd0, done}, 64'd0);
      chk("R11 unknown code no change", {hi_q, lo_q}, {m_hi, m_lo});
   endtask

   initial begin
      #(20 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      t_mult(6'd24, 32'hFFFF_FFFD, 32'd7, 1'b1);
      t_mult(6'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      t_mult(6'd24, 32'h8000_0000, 32'h8000_0000, 1'b1);

      t_moves(32'd0, 32'hFFFF_FFFF);
      t_accum(6'd29, 32'd1, 32'd1, 1'b0, 1'b0);
      t_accum(6'd28, 32'hFFFF_FFFE, 32'd3, 1'b1, 1'b0);
      t_moves(32'd0, 32'd0);
      t_accum(6'd46, 32'd1, 32'd1, 1'b1, 1'b1);
      t_accum(6'd47, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1);

      t_div(32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0);
      t_div(32'd7, 32'hFFFF_FFFE, 1'b1, 1'b1);
      t_div(32'd100, 32'd7, 1'b0, 1'b0);
      t_div(32'hFFFF_FFFF, 32'd3, 1'b0, 1'b0);

      t_special("R7 signed overflow", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000);
      t_special("R8 zero, negative", 32'hFFFF_FF00, 32'd0, 1'b1, 32'hFFFF_FF00, 32'd1);
      t_special("R8 zero, positive", 32'd55, 32'd0, 1'b1, 32'd55, 32'hFFFF_FFFF);
      t_special("R9 zero, small", 32'h0000_FFFF, 32'd0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
      t_special("R9 zero, large", 32'h0001_0000, 32'd0, 1'b0, 32'h0001_0000, 32'hFFFF_FFFF);

      t_illegal(6'd0);
      t_illegal(6'd63);

      summary();
      $finish;
   end

endmodule